// File: doc/BRIEF.md
# Non-Maskable Interrupt Source Controller

This block gathers three non-maskable interrupt causes: an edge on the external pin (when that pin is in interrupt mode), an oscillator fault pulse and a flash access-violation pulse. Each cause has its own sticky flag and its own enable bit. The block drives a single interrupt request to the processor, which is high while any flag is set together with its enable. No global interrupt mask gates this request. While the request is high, the block also presents the fixed vector address.

When the processor takes the interrupt, it pulses the accept strobe. The hardware then clears every enable bit in one step. The flags stay set, because several causes share the one vector and software has to find out which one fired. Software reads the flags and enables on two readback buses. It clears flags and sets enables again through a byte-wide write port with a select line.

The pin's active edge comes from an edge-select input. The block compares each pin sample, XORed with the edge select, against the value from the previous cycle. A change of edge select in interrupt mode can therefore look like an edge by itself, depending on the pin level. In reset mode the pin never raises its flag.

Top module: `nmi_source_ctrl`

## Requirements
- R1: `nmi_req` is high exactly when some source has both its flag and its enable set. Bit 0 is the pin, bit 1 the oscillator fault and bit 2 the flash violation, on both readback buses. No other input gates the request.
- R2: A cycle with `nmi_accept` high clears all three enable bits at the next clock edge. This holds even if an enable write happens in the same cycle. The accept leaves every flag unchanged.
- R3: With `pin_nmi_mode`=1, the pin flag is set one clock edge after a rising pin edge when `edge_falling`=0, and after a falling pin edge when `edge_falling`=1. An edge of the other polarity does not set it.
- R4: With `pin_nmi_mode`=0, no change of the pin level or of `edge_falling` sets the pin flag.
- R5: With `pin_nmi_mode`=1, a change of `edge_falling` is taken as an edge in two cases: 0 to 1 while the pin is low, or 1 to 0 while the pin is high. It then sets the pin flag. The other two combinations do not set it.
- R6: A high cycle on `osc_fault_pulse` sets flag bit 1, and a high cycle on `flash_viol_pulse` sets flag bit 2, each one clock edge later.
- R7: With `reg_wr_en`=1, `reg_wr_sel`=0 loads the flags from `reg_wr_data[2:0]`, and `reg_wr_sel`=1 loads the enables from `reg_wr_data[2:0]`. Bits [7:3] of the data are ignored.
- R8: If a source event and a flag write of 0 to that source happen in the same cycle, the flag ends up set.
- R9: While reset is asserted, and after it is released, all flags and enables read 0, `nmi_req` is 0 and `nmi_vector` is 0.
- R10: `nmi_vector` equals 16'hFFFC while `nmi_req` is high, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up clear) |
| pin_level | input | 1 | Synchronized level of the external interrupt pin |
| pin_nmi_mode | input | 1 | 1: pin acts as interrupt source, 0: reset mode |
| edge_falling | input | 1 | Edge select: 0 rising, 1 falling |
| osc_fault_pulse | input | 1 | One-cycle oscillator fault event |
| flash_viol_pulse | input | 1 | One-cycle flash access violation event |
| nmi_accept | input | 1 | Processor has taken the interrupt |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | Write target: 0 flags, 1 enables |
| reg_wr_data | input | 8 | Write data, bits [2:0] used |
| nmi_req | output | 1 | Non-maskable interrupt request |
| nmi_vector | output | 16 | Vector address, valid with the request |
| flag_rd | output | 3 | Flag readback |
| enable_rd | output | 3 | Enable readback |

## Verification
All state in the block sits in three flag bits, three enable bits and one stored edge sample, and the readback buses show all of them except the stored sample. A wrong flag or enable bit is therefore visible on the first sampled cycle after the edge that wrote it, and `nmi_req` and `nmi_vector` show any disagreement in the pending logic in the same cycle. A stale or wrong stored edge sample shows no difference at the ports until the next pin or edge-select change in interrupt mode. That is why the stimulus changes the pin and the edge select in both directions, with both pin levels, in both modes.

// File: rtl/nmi_pkg.sv
package nmi_pkg;
  localparam int NMI_SRC_N = 3;
  localparam int IDX_PIN   = 0;
  localparam int IDX_OSC   = 1;
  localparam int IDX_FLASH = 2;
endpackage

// File: rtl/nmi_rst_sync.sv
module nmi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_nxt;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/nmi_pin_edge.sv
module nmi_pin_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_level,
  input  logic nmi_mode,
  input  logic edge_sel,
  output logic edge_evt
);
  // Polarity-folded sample: a select change looks like a level change.
  logic cur_x;
  logic prev_x_q;
  logic prev_x_nxt;

  assign cur_x = pin_level ^ edge_sel;

  always_comb begin
    prev_x_nxt = cur_x;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_x_q <= 1'b0;
    else        prev_x_q <= prev_x_nxt;
  end

  assign edge_evt = nmi_mode & cur_x & ~prev_x_q;
endmodule

// File: rtl/nmi_flag_bank.sv
module nmi_flag_bank #(
  parameter int N     = 3,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     set_evt,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic             accept,
  output logic [N-1:0]     flags,
  output logic [N-1:0]     enables
);
  localparam int HI_W = REG_W - N;

  logic wr_flags;
  logic wr_enables;
  logic unused_hi;

  assign wr_flags   = wr_en & ~wr_sel;
  assign wr_enables = wr_en &  wr_sel;
  assign unused_hi  = ^wr_data[REG_W-1 -: HI_W];

  for (genvar i = 0; i < N; i++) begin : g_src
    logic flag_q, flag_nxt, flag_ld;
    logic en_q, en_nxt, en_ld;

    // Flag: new event wins over a software clear in the same cycle.
    always_comb begin
      flag_ld  = wr_flags | set_evt[i];
      flag_nxt = set_evt[i] | (wr_flags ? wr_data[i] : flag_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (flag_ld) flag_q <= flag_nxt;
    end

    // Enable: acceptance wins over a software write in the same cycle.
    always_comb begin
      en_ld  = accept | wr_enables;
      en_nxt = accept ? 1'b0 : wr_data[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_q <= 1'b0;
      else if (en_ld) en_q <= en_nxt;
    end

    assign flags[i]   = flag_q;
    assign enables[i] = en_q;
  end
endmodule

// File: rtl/nmi_req_merge.sv
module nmi_req_merge #(
  parameter int          N        = 3,
  parameter int          VEC_W    = 16,
  parameter logic [15:0] VEC_ADDR = 16'hFFFC
) (
  input  logic [N-1:0]     flags,
  input  logic [N-1:0]     enables,
  output logic             nmi_req,
  output logic [VEC_W-1:0] nmi_vector
);
  logic [N-1:0] pending;

  assign pending    = flags & enables;
  assign nmi_req    = |pending;
  assign nmi_vector = nmi_req ? VEC_W'(VEC_ADDR) : '0;
endmodule

// File: rtl/nmi_source_ctrl.sv
module nmi_source_ctrl
  import nmi_pkg::*;
#(
  parameter int          REG_W       = 8,
  parameter int          VEC_W       = 16,
  parameter logic [15:0] VEC_ADDR    = 16'hFFFC,
  parameter int          SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pin_level,
  input  logic                 pin_nmi_mode,
  input  logic                 edge_falling,
  input  logic                 osc_fault_pulse,
  input  logic                 flash_viol_pulse,
  input  logic                 nmi_accept,
  input  logic                 reg_wr_en,
  input  logic                 reg_wr_sel,
  input  logic [REG_W-1:0]     reg_wr_data,
  output logic                 nmi_req,
  output logic [VEC_W-1:0]     nmi_vector,
  output logic [NMI_SRC_N-1:0] flag_rd,
  output logic [NMI_SRC_N-1:0] enable_rd
);
  logic                 rst_sync_n;
  logic                 pin_evt;
  logic [NMI_SRC_N-1:0] set_evt;

  nmi_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  nmi_pin_edge u_edge (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .pin_level (pin_level),
    .nmi_mode  (pin_nmi_mode),
    .edge_sel  (edge_falling),
    .edge_evt  (pin_evt)
  );

  assign set_evt[IDX_PIN]   = pin_evt;
  assign set_evt[IDX_OSC]   = osc_fault_pulse;
  assign set_evt[IDX_FLASH] = flash_viol_pulse;

  nmi_flag_bank #(.N(NMI_SRC_N), .REG_W(REG_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_evt (set_evt),
    .wr_en   (reg_wr_en),
    .wr_sel  (reg_wr_sel),
    .wr_data (reg_wr_data),
    .accept  (nmi_accept),
    .flags   (flag_rd),
    .enables (enable_rd)
  );

  nmi_req_merge #(.N(NMI_SRC_N), .VEC_W(VEC_W), .VEC_ADDR(VEC_ADDR)) u_merge (
    .flags      (flag_rd),
    .enables    (enable_rd),
    .nmi_req    (nmi_req),
    .nmi_vector (nmi_vector)
  );
endmodule

// File: rtl/nmi_source_ctrl_chk.sv
module nmi_source_ctrl_chk #(
  parameter int          VEC_W    = 16,
  parameter logic [15:0] VEC_ADDR = 16'hFFFC
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pin_nmi_mode,
  input logic             osc_fault_pulse,
  input logic             flash_viol_pulse,
  input logic             nmi_accept,
  input logic             reg_wr_en,
  input logic             reg_wr_sel,
  input logic             nmi_req,
  input logic [VEC_W-1:0] nmi_vector,
  input logic [2:0]       flag_rd,
  input logic [2:0]       enable_rd
);
  AST_REQ_FROM_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req == |(flag_rd & enable_rd)); // R1

  AST_ACCEPT_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_accept |=> (enable_rd == 3'b000)); // R2

  AST_ACCEPT_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_accept && !(reg_wr_en && !reg_wr_sel)) |=> ((flag_rd & $past(flag_rd)) == $past(flag_rd))); // R2

  AST_RESET_MODE_NO_PIN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_nmi_mode && !(reg_wr_en && !reg_wr_sel)) |=> (flag_rd[0] == $past(flag_rd[0]))); // R4

  AST_OSC_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    osc_fault_pulse |=> flag_rd[1]); // R6

  AST_VIOL_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    flash_viol_pulse |=> flag_rd[2]); // R6

  AST_VECTOR_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> (nmi_vector == VEC_W'(VEC_ADDR))); // R10

  AST_NO_VECTOR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !nmi_req |-> (nmi_vector == '0)); // R10
endmodule

bind nmi_source_ctrl nmi_source_ctrl_chk #(.VEC_W(VEC_W), .VEC_ADDR(VEC_ADDR)) u_chk (
  .clk              (clk),
  .rst_n            (rst_sync_n),
  .pin_nmi_mode     (pin_nmi_mode),
  .osc_fault_pulse  (osc_fault_pulse),
  .flash_viol_pulse (flash_viol_pulse),
  .nmi_accept       (nmi_accept),
  .reg_wr_en        (reg_wr_en),
  .reg_wr_sel       (reg_wr_sel),
  .nmi_req          (nmi_req),
  .nmi_vector       (nmi_vector),
  .flag_rd          (flag_rd),
  .enable_rd        (enable_rd)
);

// File: tb/tb_nmi_source_ctrl.sv
`timescale 1ns/1ps
module tb_nmi_source_ctrl;
  logic        clk;
  logic        rst_n;
  logic        pin_level, pin_nmi_mode, edge_falling;
  logic        osc_fault_pulse, flash_viol_pulse, nmi_accept;
  logic        reg_wr_en, reg_wr_sel;
  logic [7:0]  reg_wr_data;
  logic        nmi_req;
  logic [15:0] nmi_vector;
  logic [2:0]  flag_rd, enable_rd;

  int n_chk  = 0;
  int n_fail = 0;

  // Reference state
  logic [2:0] m_flag, m_en;
  logic       m_prev;

  nmi_source_ctrl dut (
    .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .pin_nmi_mode(pin_nmi_mode),
    .edge_falling(edge_falling), .osc_fault_pulse(osc_fault_pulse),
    .flash_viol_pulse(flash_viol_pulse), .nmi_accept(nmi_accept),
    .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
    .nmi_req(nmi_req), .nmi_vector(nmi_vector), .flag_rd(flag_rd), .enable_rd(enable_rd)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic exp_pin_evt(input logic mode, pin, sel, prev);
    return mode & (pin ^ sel) & ~prev;
  endfunction

  function automatic logic [2:0] exp_flags(input logic [2:0] f, evt, input logic wr, wsel,
                                          input logic [7:0] d);
    logic [2:0] base;
    base = (wr && !wsel) ? d[2:0] : f;
    return base | evt;
  endfunction

  function automatic logic [2:0] exp_enables(input logic [2:0] e, input logic acc, wr, wsel,
                                            input logic [7:0] d);
    if (acc) return 3'b000;
    if (wr && wsel) return d[2:0];
    return e;
  endfunction

  function automatic logic [15:0] exp_vector(input logic [2:0] f, e);
    return (|(f & e)) ? 16'hFFFC : 16'h0000;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    pin_level = 0; pin_nmi_mode = 0; edge_falling = 0;
    osc_fault_pulse = 0; flash_viol_pulse = 0; nmi_accept = 0;
    reg_wr_en = 0; reg_wr_sel = 0; reg_wr_data = 8'h00;
  endtask

  task automatic cyc(input logic mode, pin, sel, osc, viol, acc, wr, wsel,
                     input logic [7:0] d, input string tag);
    logic [2:0] evt;
    @(negedge clk);
    pin_nmi_mode = mode; pin_level = pin; edge_falling = sel;
    osc_fault_pulse = osc; flash_viol_pulse = viol; nmi_accept = acc;
    reg_wr_en = wr; reg_wr_sel = wsel; reg_wr_data = d;
    evt    = {viol, osc, exp_pin_evt(mode, pin, sel, m_prev)};
    m_flag = exp_flags(m_flag, evt, wr, wsel, d);
    m_en   = exp_enables(m_en, acc, wr, wsel, d);
    m_prev = pin ^ sel;
    @(posedge clk);
    #1;
    chk({tag, " flags"},   {13'd0, flag_rd},   {13'd0, m_flag});
    chk({tag, " enables"}, {13'd0, enable_rd}, {13'd0, m_en});
    chk({tag, " R1 req"},  {15'd0, nmi_req},   {15'd0, |(m_flag & m_en)});
    chk({tag, " R10 vec"}, nmi_vector,         exp_vector(m_flag, m_en));
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    idle_inputs();
    rst_n = 0;
    m_flag = 0; m_en = 0; m_prev = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset flags",   {13'd0, flag_rd},   16'd0);
    chk("R9 reset enables", {13'd0, enable_rd}, 16'd0);
    chk("R9 reset req",     {15'd0, nmi_req},   16'd0);
    chk("R9 reset vector",  nmi_vector,         16'd0);
    @(negedge clk);
    rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    chk("R9 after release flags", {13'd0, flag_rd}, 16'd0);

    // R3 rising edge, then enable and request
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 8'h00, "R3 setup");
    cyc(1, 1, 0, 0, 0, 0, 0, 0, 8'h00, "R3 rise");
    chk("R3 rising sets pin flag", {15'd0, flag_rd[0]}, 16'd1);
    cyc(1, 1, 0, 0, 0, 0, 1, 1, 8'h01, "R1 enable pin");
    chk("R1 request high", {15'd0, nmi_req}, 16'd1);
    chk("R10 vector FFFC", nmi_vector, 16'hFFFC);

    // R2 accept beats enable write, flags kept
    cyc(1, 1, 0, 0, 0, 1, 1, 1, 8'h07, "R2 accept");
    chk("R2 enables cleared", {13'd0, enable_rd}, 16'd0);
    chk("R2 flags kept",      {13'd0, flag_rd},   16'd1);
    chk("R2 request dropped", {15'd0, nmi_req},   16'd0);

    // R7 writes ignore upper bits
    cyc(1, 1, 0, 0, 0, 0, 1, 0, 8'hF8, "R7 flag write");
    chk("R7 flags cleared by F8", {13'd0, flag_rd}, 16'd0);
    cyc(1, 1, 0, 0, 0, 0, 1, 1, 8'hFA, "R7 enable write");
    chk("R7 enable from FA", {13'd0, enable_rd}, 16'd2);

    // R5 select 0->1 with pin high: no event
    cyc(1, 1, 1, 0, 0, 0, 0, 0, 8'h00, "R5 sel up pin high");
    chk("R5 no event sel up pin high", {15'd0, flag_rd[0]}, 16'd0);
    // R3 falling edge
    cyc(1, 0, 1, 0, 0, 0, 0, 0, 8'h00, "R3 fall");
    chk("R3 falling sets pin flag", {15'd0, flag_rd[0]}, 16'd1);
    cyc(1, 0, 1, 0, 0, 0, 1, 0, 8'h00, "R7 clear");
    // R5 select 1->0 with pin low: no event
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 8'h00, "R5 sel down pin low");
    chk("R5 no event sel down pin low", {15'd0, flag_rd[0]}, 16'd0);
    // R3 falling edge with rising select ignored
    cyc(1, 1, 0, 0, 0, 0, 0, 0, 8'h00, "R3 rise again");
    cyc(1, 1, 0, 0, 0, 0, 1, 0, 8'h00, "R7 clear2");
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 8'h00, "R3 wrong polarity");
    chk("R3 falling ignored on rising select", {15'd0, flag_rd[0]}, 16'd0);
    // R5 select 0->1 with pin low: event
    cyc(1, 0, 1, 0, 0, 0, 0, 0, 8'h00, "R5 sel up pin low");
    chk("R5 event sel up pin low", {15'd0, flag_rd[0]}, 16'd1);
    cyc(1, 1, 1, 0, 0, 0, 1, 0, 8'h00, "R7 clear3");
    // R5 select 1->0 with pin high: event
    cyc(1, 1, 0, 0, 0, 0, 0, 0, 8'h00, "R5 sel down pin high");
    chk("R5 event sel down pin high", {15'd0, flag_rd[0]}, 16'd1);
    cyc(1, 1, 0, 0, 0, 0, 1, 0, 8'h00, "R7 clear4");

    // R4 reset mode: toggle pin and select
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 8'h00, "R4 a");
    cyc(0, 1, 0, 0, 0, 0, 0, 0, 8'h00, "R4 b");
    cyc(0, 1, 1, 0, 0, 0, 0, 0, 8'h00, "R4 c");
    cyc(0, 0, 1, 0, 0, 0, 0, 0, 8'h00, "R4 d");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 8'h00, "R4 e");
    chk("R4 reset mode no pin flag", {15'd0, flag_rd[0]}, 16'd0);

    // R8 event with same-cycle clear
    cyc(0, 0, 0, 1, 0, 0, 1, 0, 8'h00, "R8 osc vs clear");
    chk("R8 osc flag survives clear", {15'd0, flag_rd[1]}, 16'd1);
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 8'h00, "R8 setup");
    cyc(1, 1, 0, 0, 0, 0, 1, 0, 8'h02, "R8 pin vs clear");
    chk("R8 pin flag survives clear", {15'd0, flag_rd[0]}, 16'd1);
    cyc(1, 1, 0, 0, 0, 0, 1, 0, 8'h00, "R7 clear5");

    // R6 and R1 masking by per-source enable
    cyc(1, 1, 0, 0, 1, 0, 0, 0, 8'h00, "R6 viol");
    chk("R6 viol flag set", {13'd0, flag_rd}, 16'd4);
    cyc(1, 1, 0, 0, 0, 0, 1, 1, 8'h03, "R1 other enables");
    chk("R1 no request without matching enable", {15'd0, nmi_req}, 16'd0);
    cyc(1, 1, 0, 0, 0, 0, 1, 1, 8'h04, "R1 viol enable");
    chk("R1 request with matching enable", {15'd0, nmi_req}, 16'd1);
    cyc(1, 1, 0, 1, 0, 1, 0, 0, 8'h00, "R6 osc with accept");
    chk("R6 osc flag set", {13'd0, flag_rd}, 16'd6);

    // Random phase
    for (int k = 0; k < 3000; k++) begin
      logic mode, pin, sel, osc, viol, acc, wr, wsel;
      logic [7:0] d;
      mode = ($urandom % 8) != 0;
      pin  = (($urandom % 3) == 0) ? ~pin_level : pin_level;
      sel  = (($urandom % 16) == 0) ? ~edge_falling : edge_falling;
      osc  = ($urandom % 20) == 0;
      viol = ($urandom % 20) == 0;
      acc  = ($urandom % 12) == 0;
      wr   = ($urandom % 6) == 0;
      wsel = $urandom % 2;
      d    = 8'($urandom);
      cyc(mode, pin, sel, osc, viol, acc, wr, wsel, d, "random R3 R5 R6 R7");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule